// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Controller

This block decides, for one DMA channel, when data may move. A trigger can come from software (a set pulse) or from an asynchronous hardware line. The hardware line is synchronized, qualified by a programmable polarity, and interpreted either as an edge event or as a level. The result is held in a trigger flag. When the flag is set and the channel is idle, the channel is armed for a run of grants. A run is either one transfer or a burst of 2^n transfers.

Each grant is a handshake: `grant_o` stays high until the data path returns `done_i`. When peripheral pacing is enabled, a grant is issued only while the peripheral request line is high. The block also holds the channel configuration word. From that word it drives the source and destination wrap flags and the priority field to the address generator and the arbiter. The last grant of each run is marked by `burst_last_o`, so the address generator knows where to wrap.

Top module: `dma_trig_ctrl`

## Requirements
- R1: A write to the configuration word stores it, and `cfg_o` returns it on the next cycle with every bit outside the mask 0x0003_CF73 read as zero. This mask applies for a 2-bit priority field. The defined bits are: 0 (peripheral pacing enable), 1 (hardware trigger select), 4 (polarity, 1 = high or rising), 5 (mode, 1 = level), 6 (burst enable), 11:8 (burst exponent), 14 (source wrap), 15 (destination wrap), and 17:16 (priority, 0 is highest). After reset the word is zero.
- R2: `src_wrap_o`, `dst_wrap_o` and `prio_o` follow config bits 14, 15 and 17:16 of the stored word.
- R3: A software set pulse raises `trig_o` on the next clock edge. A software clear pulse forces `trig_o` low on the next edge, and it wins over a set pulse in the same cycle. After reset `trig_o` and `grant_o` are low.
- R4: With config bit 6 clear, each trigger yields exactly one grant, and the flag is consumed when the run starts.
- R5: With config bit 6 set, one trigger yields 2^n grants back to back, where n is config bits 11:8. Exponent values above 10 act as 10, which gives 1024 grants.
- R6: With config bit 1 set and bit 5 clear, the hardware line passes through a two-flop synchronizer. Only the edge selected by bit 4 sets the flag: rising when 1, falling when 0. Holding the line does not retrigger, and the opposite edge does nothing.
- R7: With config bits 1 and 5 set, the flag follows the active level of the synchronized line. Runs repeat while the line is active and stop once it goes inactive.
- R8: With config bit 1 clear, the hardware line has no effect on the flag or on the grants.
- R9: With config bit 0 set, `grant_o` is high only while `periph_req_i` is high. A run that has started waits for the request.
- R10: `grant_o` stays high until `done_i` is seen. `burst_last_o` is high only together with the final grant of a run.
- R11: A trigger that arrives during a run, or in the same cycle that a run consumes the flag, stays latched and starts exactly one further run after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration word write data |
| cfg_o | output | 32 | Stored configuration word, undefined bits zero |
| sw_set_i | input | 1 | Software trigger set pulse |
| sw_clr_i | input | 1 | Software trigger clear pulse |
| hw_trig_i | input | 1 | Asynchronous hardware trigger line |
| periph_req_i | input | 1 | Peripheral request used for pacing |
| done_i | input | 1 | Transfer completion for the current grant |
| grant_o | output | 1 | Permission to perform one transfer |
| burst_last_o | output | 1 | Current grant is the final one of its run |
| trig_o | output | 1 | Trigger flag status |
| src_wrap_o | output | 1 | Source burst wrap enable |
| dst_wrap_o | output | 1 | Destination burst wrap enable |
| prio_o | output | PRIO_W | Channel priority, 0 highest |

## Verification
Two functions can land in the same cycle: a new trigger, and the consumption of the flag when an idle channel starts a run. The bench provokes this by holding the software set pulse for two cycles. The second cycle of the pulse coincides with the start of the run. The scoreboard must then see exactly two single-grant runs, no more and no fewer. Set and clear are also driven together, and the check is that the flag stays low and no grant follows.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned B_PREQ    = 0;
  localparam int unsigned B_HWSEL   = 1;
  localparam int unsigned B_POL     = 4;
  localparam int unsigned B_LVL     = 5;
  localparam int unsigned B_BURST   = 6;
  localparam int unsigned B_EXP_LO  = 8;
  localparam int unsigned EXP_W     = 4;
  localparam int unsigned B_SWRAP   = 14;
  localparam int unsigned B_DWRAP   = 15;
  localparam int unsigned B_PRIO_LO = 16;

  function automatic logic [CFG_W-1:0] cfg_mask(input int unsigned prio_w);
    logic [CFG_W-1:0] m;
    m = '0;
    m[B_PREQ]  = 1'b1;
    m[B_HWSEL] = 1'b1;
    m[B_POL]   = 1'b1;
    m[B_LVL]   = 1'b1;
    m[B_BURST] = 1'b1;
    for (int i = 0; i < EXP_W; i++) m[B_EXP_LO+i] = 1'b1;
    m[B_SWRAP] = 1'b1;
    m[B_DWRAP] = 1'b1;
    for (int i = 0; i < prio_w; i++) m[B_PRIO_LO+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dma_trig_sync.sv
module dma_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic ff [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff[0] <= 1'b0;
    else         ff[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff[i] <= 1'b0;
      else         ff[i] <= ff[i-1];
    end
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/dma_trig_cond.sv
module dma_trig_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic pol_high_i,
  output logic event_o,
  output logic active_o
);
  logic s_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_prev_q <= 1'b0;
    else         s_prev_q <= s_i;
  end

  // edge detection on the raw synchronized line, so polarity changes cause no event
  assign event_o  = pol_high_i ? (s_i & ~s_prev_q) : (~s_i & s_prev_q);
  assign active_o = pol_high_i ? s_i : ~s_i;
endmodule

// File: rtl/dma_trig_flag.sv
module dma_trig_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic hw_sel_i,
  input  logic lvl_mode_i,
  input  logic hw_event_i,
  input  logic hw_active_i,
  input  logic consume_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    if (hw_sel_i && lvl_mode_i) flag_d = hw_active_i | sw_set_i;
    else flag_d = (flag_q & ~consume_i) | sw_set_i | (hw_sel_i & hw_event_i);
    if (sw_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dma_trig_burst.sv
module dma_trig_burst #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             gate_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             grant_o,
  output logic             last_o
);
  logic             busy_q;
  logic [LEN_W-1:0] cnt_q, lim_q;
  logic             at_lim;

  assign start_o = ~busy_q & flag_i;
  assign grant_o = busy_q & gate_i;
  assign at_lim  = (cnt_q == lim_q);
  assign last_o  = grant_o & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= len_m1_i;
    end else if (grant_o && done_i) begin
      if (at_lim) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
  import dma_trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_EXP     = 10,
  parameter int unsigned PRIO_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_o,
  input  logic              sw_set_i,
  input  logic              sw_clr_i,
  input  logic              hw_trig_i,
  input  logic              periph_req_i,
  input  logic              done_i,
  output logic              grant_o,
  output logic              burst_last_o,
  output logic              trig_o,
  output logic              src_wrap_o,
  output logic              dst_wrap_o,
  output logic [PRIO_W-1:0] prio_o
);
  localparam logic [CFG_W-1:0] MASK    = cfg_mask(PRIO_W);
  localparam int unsigned      LEN_W   = MAX_EXP;
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic [CFG_W-1:0] cfg_q;
  logic             hw_s, hw_event, hw_active, flag, start;
  logic [EXP_W-1:0] exp_raw, exp_eff;
  logic [LEN_W:0]   len_full;
  logic [LEN_W-1:0] len_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i & MASK;
  end

  assign cfg_o      = cfg_q;
  assign src_wrap_o = cfg_q[B_SWRAP];
  assign dst_wrap_o = cfg_q[B_DWRAP];
  assign prio_o     = cfg_q[B_PRIO_LO +: PRIO_W];

  assign exp_raw  = cfg_q[B_EXP_LO +: EXP_W];
  assign exp_eff  = (exp_raw > EXP_CAP) ? EXP_CAP : exp_raw;
  assign len_full = ((LEN_W+1)'(1) << exp_eff) - (LEN_W+1)'(1);
  assign len_m1   = cfg_q[B_BURST] ? len_full[LEN_W-1:0] : '0;

  dma_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hw_trig_i),
    .q_o   (hw_s)
  );

  dma_trig_cond i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_i       (hw_s),
    .pol_high_i(cfg_q[B_POL]),
    .event_o   (hw_event),
    .active_o  (hw_active)
  );

  dma_trig_flag i_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_set_i   (sw_set_i),
    .sw_clr_i   (sw_clr_i),
    .hw_sel_i   (cfg_q[B_HWSEL]),
    .lvl_mode_i (cfg_q[B_LVL]),
    .hw_event_i (hw_event),
    .hw_active_i(hw_active),
    .consume_i  (start),
    .flag_o     (flag)
  );

  dma_trig_burst #(.LEN_W(LEN_W)) i_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flag_i  (flag),
    .len_m1_i(len_m1),
    .gate_i  (~cfg_q[B_PREQ] | periph_req_i),
    .done_i  (done_i),
    .start_o (start),
    .grant_o (grant_o),
    .last_o  (burst_last_o)
  );

  assign trig_o = flag;
endmodule

// File: rtl/dma_trig_chk.sv
module dma_trig_chk
  import dma_trig_pkg::*;
#(
  parameter int unsigned PRIO_W = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] cfg_wdata_i,
  input logic [31:0] cfg_o,
  input logic        sw_set_i,
  input logic        sw_clr_i,
  input logic        periph_req_i,
  input logic        done_i,
  input logic        grant_o,
  input logic        burst_last_o,
  input logic        trig_o
);
  localparam logic [CFG_W-1:0] MASK = cfg_mask(PRIO_W);

  AST_CFG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_o == ($past(cfg_wdata_i) & MASK)); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> !trig_o); // R3
  AST_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i && !sw_clr_i) |=> trig_o); // R11
  AST_PACED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && cfg_o[0]) |-> periph_req_i); // R9
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !done_i && !cfg_o[0] && !cfg_we_i) |=> grant_o); // R10
  AST_LAST_IN_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_last_o |-> grant_o); // R10
endmodule

bind dma_trig_ctrl dma_trig_chk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/test_dma_trig_ctrl.sv
module test_dma_trig_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_o;
  logic        sw_set_i = 1'b0, sw_clr_i = 1'b0, hw_trig_i = 1'b0;
  logic        periph_req_i = 1'b0, done_i = 1'b0;
  logic        grant_o, burst_last_o, trig_o, src_wrap_o, dst_wrap_o;
  logic [1:0]  prio_o;

  int    n_chk = 0, n_fail = 0;
  int    exp_q[$];
  int    run_len = 0, n_bursts = 0;
  bit    free_mode = 0, hold_done = 0;
  int    free_len = 1;
  string cur_req = "R4";

  dma_trig_ctrl i_dma_trig_ctrl (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // done responder and scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && grant_o && !hold_done) begin
      run_len++;
      if (burst_last_o) begin
        n_bursts++;
        if (exp_q.size() != 0) begin
          int e;
          e = exp_q.pop_front();
          chk(run_len == e, cur_req, run_len, e);
        end else if (free_mode) chk(run_len == free_len, cur_req, run_len, free_len);
        else chk(1'b0, cur_req, run_len, 0);
        run_len = 0;
      end
    end
    done_i <= grant_o && !hold_done;
  end

  task automatic wcfg(input logic [31:0] v);
    @(negedge clk_i); #1; cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i); #1; cfg_we_i = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk_i); #1; sw_set_i = 1'b1;
    @(negedge clk_i); #1; sw_set_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(grant_o == 1'b0, "R3 reset grant", grant_o, 0);
    chk(trig_o == 1'b0, "R3 reset trig", trig_o, 0);
    chk(cfg_o == 32'h0, "R1 reset cfg", cfg_o, 0);

    // R1 / R2: readback mask and field outputs
    wcfg(32'hFFFF_FFFF);
    chk(cfg_o == 32'h0003_CF73, "R1 mask", cfg_o, 32'h0003_CF73);
    chk(src_wrap_o && dst_wrap_o, "R2 wrap", {src_wrap_o, dst_wrap_o}, 3);
    chk(prio_o == 2'd3, "R2 prio", prio_o, 3);
    wcfg(32'h0000_4000);
    chk(src_wrap_o && !dst_wrap_o && prio_o == 0, "R2 src only",
        {src_wrap_o, dst_wrap_o, prio_o}, 32'h8);

    // R4 single software trigger
    wcfg(32'h0); cur_req = "R4"; exp_q.push_back(1);
    @(negedge clk_i); #1; sw_set_i = 1'b1;
    @(negedge clk_i);
    chk(trig_o == 1'b1, "R3 set", trig_o, 1);
    #1; sw_set_i = 1'b0;
    idle(10);
    chk(trig_o == 1'b0, "R4 consumed", trig_o, 0);
    chk(exp_q.size() == 0, "R4 runs", exp_q.size(), 0);

    // R5 burst of 8 and capped exponent
    wcfg(32'h0000_0340); cur_req = "R5"; exp_q.push_back(8);
    pulse_set(); idle(20);
    chk(exp_q.size() == 0, "R5 burst8", exp_q.size(), 0);
    wcfg(32'h0000_0F40); exp_q.push_back(1024);
    pulse_set(); idle(1040);
    chk(exp_q.size() == 0, "R5 cap1024", exp_q.size(), 0);

    // R6 rising edge, hold and falling edge ignored
    wcfg(32'h0000_0012); cur_req = "R6"; exp_q.push_back(1);
    @(negedge clk_i); #1; hw_trig_i = 1'b1;
    idle(20);
    chk(exp_q.size() == 0 && trig_o == 1'b0, "R6 rising once", exp_q.size(), 0);
    hw_trig_i = 1'b0; idle(10);
    // falling polarity
    wcfg(32'h0000_0002);
    hw_trig_i = 1'b1; idle(10);
    chk(trig_o == 1'b0, "R6 rise ignored when low pol", trig_o, 0);
    exp_q.push_back(1); hw_trig_i = 1'b0; idle(20);
    chk(exp_q.size() == 0, "R6 falling", exp_q.size(), 0);

    // R8 hardware line ignored when not selected
    wcfg(32'h0000_0010); cur_req = "R8"; b = n_bursts;
    hw_trig_i = 1'b1; idle(10); hw_trig_i = 1'b0; idle(10);
    chk(n_bursts == b && trig_o == 1'b0, "R8 ignored", n_bursts - b, 0);

    // R7 level mode
    wcfg(32'h0000_0032); cur_req = "R7"; free_mode = 1; free_len = 1; b = n_bursts;
    hw_trig_i = 1'b1; idle(20);
    chk(n_bursts - b >= 5, "R7 repeating", n_bursts - b, 5);
    hw_trig_i = 1'b0; idle(10); b = n_bursts; idle(20);
    chk(n_bursts == b && trig_o == 1'b0, "R7 stopped", n_bursts - b, 0);
    free_mode = 0;

    // R9 peripheral pacing
    wcfg(32'h0000_0001); cur_req = "R9";
    pulse_set(); idle(10);
    chk(grant_o == 1'b0, "R9 gated", grant_o, 0);
    exp_q.push_back(1); periph_req_i = 1'b1; idle(10);
    chk(exp_q.size() == 0, "R9 released", exp_q.size(), 0);
    periph_req_i = 1'b0;

    // R3 clear wins over set
    wcfg(32'h0); cur_req = "R3"; b = n_bursts;
    @(negedge clk_i); #1; sw_set_i = 1'b1; sw_clr_i = 1'b1;
    @(negedge clk_i);
    chk(trig_o == 1'b0, "R3 clear wins", trig_o, 0);
    #1; sw_set_i = 1'b0; sw_clr_i = 1'b0;
    idle(10);
    chk(n_bursts == b, "R3 no run", n_bursts - b, 0);

    // R11 trigger during a burst is latched
    wcfg(32'h0000_0440); cur_req = "R11"; exp_q.push_back(16); exp_q.push_back(16);
    pulse_set(); idle(5); pulse_set();
    chk(trig_o == 1'b1 && grant_o == 1'b1, "R11 latched mid-run", trig_o, 1);
    idle(50);
    chk(exp_q.size() == 0, "R11 two bursts", exp_q.size(), 0);

    // R11 set coinciding with consumption
    wcfg(32'h0); exp_q.push_back(1); exp_q.push_back(1); b = n_bursts;
    @(negedge clk_i); #1; sw_set_i = 1'b1;
    idle(2); sw_set_i = 1'b0;
    idle(20);
    chk(n_bursts - b == 2 && exp_q.size() == 0, "R11 coincide", n_bursts - b, 2);

    // R10 grant held until done
    cur_req = "R10"; hold_done = 1; exp_q.push_back(1);
    pulse_set(); idle(10);
    chk(grant_o == 1'b1 && burst_last_o == 1'b1, "R10 held", grant_o, 1);
    hold_done = 0; idle(10);
    chk(grant_o == 1'b0 && exp_q.size() == 0, "R10 released", grant_o, 0);

    finish_run();
  end
endmodule